// File: doc/BRIEF.md
# Multi-Mode 8-bit Timer

This block is a byte-wide timer peripheral. It has one 8-bit counter, which serves three modes selected in a control register. In compare mode the counter runs up to a programmed limit and then restarts from zero, requesting an interrupt and toggling the output pin each time. In PWM mode the counter runs freely through all 256 values. A compare against the data register shapes a pulse-width waveform on the output pin, and both the compare and the wrap raise their own event. In capture mode the counter behaves as in compare mode, and an edge on an external event input copies the running count into a capture register.

The counter advances on a tick. The tick comes either from one of seven power-of-two divisions of the system clock or from rising edges of an external count input. Both external inputs pass through a two-flop synchronizer before edge detection. Software reaches the block over a simple register bus with a write strobe, an address and a combinational read path. The capture register and the data register share one address: reads of that address are steered by the mode, and writes always land in the data register. The two event outputs are one-cycle pulses that an interrupt controller outside the block collects.

Top module: `mtimer8`

## Requirements
- R1: Under reset the control register reads 0x00, the counter 0x00, the data register 0xFF and the capture register 0x00. The output pin and both event pulses are low.
- R2: The control register at address 0x92 holds, from bit 7 down, enable, pin enable, mode[1:0], clock select[2:0] and a clear strobe in bit 0. Bit 0 always reads back as 0.
- R3: Writing the control register with bit 0 set clears the counter at that write's clock edge, and this takes priority over a tick. Writing bit 0 as 0 leaves the counter alone.
- R4: Clock-select values 0 to 6 advance the counter once every 2, 4, 8, 32, 128, 512 or 2048 system clocks while enabled. The first advance comes that many clocks after enable is written.
- R5: Clock select 7 advances the counter once per rising edge of `ext_count`. The change appears in the counter on the third clock edge after the input rises.
- R6: While enable (bit 7) is 0 the counter holds, no event pulse occurs, the output pin is low and the prescaler restarts from zero.
- R7: In compare mode (mode 00), a tick that finds the counter equal to the data register sets the counter to 0 and toggles the output state. It also gives a one-cycle `irq_match` pulse in the following cycle. Any other tick increments the counter.
- R8: In PWM mode (mode 01), a compare never clears the counter. A tick at 0xFF wraps it to 0x00 and pulses `irq_ovf`, and a tick at a count equal to the data register pulses `irq_match`.
- R9: In PWM mode the output pin is high while the counter is below the data register and low otherwise. Data 0x00 gives a constant low, and data 0xFF is low only at count 0xFF.
- R10: In capture mode (mode 1x), the selected edge of `cap_event` (rising when `cap_falling` is 0, falling when it is 1) loads the counter into the capture register. The edge takes effect at the third clock edge after the input changes. Compare events act as in R7, and the output pin stays low.
- R11: Reads of address 0x94 return the capture register while mode bit 1 is set and the data register otherwise. Writes to 0x94 always update the data register. Address 0x93 reads the counter, and other addresses read 0x00.
- R12: When pin enable (bit 6) is 0, the output pin is low in every mode.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_wr | input | 1 | Register write strobe |
| bus_addr | input | 8 | Register address |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data for `bus_addr` (combinational) |
| ext_count | input | 1 | External count input, asynchronous |
| cap_event | input | 1 | Capture trigger input, asynchronous |
| cap_falling | input | 1 | Static capture polarity: 0 rising, 1 falling |
| tmr_out | output | 1 | Timer output pin |
| irq_match | output | 1 | Compare event pulse |
| irq_ovf | output | 1 | PWM wrap event pulse |

## Verification
The checker watches several properties on every cycle. The pin-enable and capture-mode gating must keep the output low. A clear strobe must never read back. Each wrap event must find the counter at zero, and only in PWM mode. In the non-PWM modes every compare event must follow a counter clear. The counter must hold while disabled, and compare pulses must never come back to back. The remaining behaviours can only be shown against the bench's reference model over whole scenarios. These are the exact division periods, the synchronizer latency on the external inputs, the value loaded by each capture edge and its polarity, the PWM duty at the 0x00 and 0xFF limits, and the mode-steered read of the shared address.

// File: rtl/mtimer8_pkg.sv
package mtimer8_pkg;

    localparam int DW    = 8;
    localparam int PRE_W = 11;

    typedef enum logic [1:0] {
        MD_TIMER   = 2'b00,
        MD_PWM     = 2'b01,
        MD_CAP     = 2'b10,
        MD_CAP_ALT = 2'b11
    } mode_e;

    // stored control bits; the clear strobe in bit 0 is never kept
    typedef struct packed {
        logic       en;
        logic       pe;
        mode_e      mode;
        logic [2:0] csel;
    } ctrl_t;

    localparam logic [2:0] CSEL_EXT = 3'd7;

    function automatic logic is_capture(mode_e m);
        return m[1];
    endfunction

    // mask of prescaler bits that must all be ones for a tick
    function automatic logic [PRE_W-1:0] div_mask(logic [2:0] csel);
        logic [PRE_W-1:0] m;
        case (csel)
            3'd0:    m = 11'h001;
            3'd1:    m = 11'h003;
            3'd2:    m = 11'h007;
            3'd3:    m = 11'h01F;
            3'd4:    m = 11'h07F;
            3'd5:    m = 11'h1FF;
            3'd6:    m = 11'h7FF;
            default: m = '0;
        endcase
        return m;
    endfunction

endpackage

// File: rtl/mtimer8_sync_edge.sv
module mtimer8_sync_edge #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic din,
    input  logic sel_fall,
    output logic edge_o
);
    localparam int LAST = STAGES - 1;

    logic [STAGES-1:0] sr;
    logic              prev;

    always_ff @(posedge clk) begin
        if (rst) begin
            sr   <= '0;
            prev <= 1'b0;
        end else begin
            sr   <= {sr[STAGES-2:0], din};
            prev <= sr[LAST];
        end
    end

    assign edge_o = sel_fall ? (prev & ~sr[LAST]) : (~prev & sr[LAST]);

endmodule

// File: rtl/mtimer8_tick_gen.sv
module mtimer8_tick_gen
    import mtimer8_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       en,
    input  logic [2:0] csel,
    input  logic       ext_rise,
    output logic       tick
);
    logic [PRE_W-1:0] pcnt;
    logic [PRE_W-1:0] mask;

    always_ff @(posedge clk) begin
        if (rst) begin
            pcnt <= '0;
        end else if (!en) begin
            pcnt <= '0;
        end else begin
            pcnt <= pcnt + 1'b1;
        end
    end

    always_comb begin
        mask = div_mask(csel);
        if (!en) begin
            tick = 1'b0;
        end else if (csel == CSEL_EXT) begin
            tick = ext_rise;
        end else begin
            tick = ((pcnt & mask) == mask);
        end
    end

endmodule

// File: rtl/mtimer8_counter.sv
module mtimer8_counter
    import mtimer8_pkg::*;
#(
    parameter int W = DW
) (
    input  logic         clk,
    input  logic         rst,
    input  mode_e        mode,
    input  logic         tick,
    input  logic         clr,
    input  logic [W-1:0] limit,
    output logic [W-1:0] cnt,
    output logic         match_pulse,
    output logic         wrap_pulse,
    output logic         toggle
);
    logic eq;
    logic free_run;

    assign eq       = (cnt == limit);
    assign free_run = (mode == MD_PWM);

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt         <= '0;
            match_pulse <= 1'b0;
            wrap_pulse  <= 1'b0;
            toggle      <= 1'b0;
        end else begin
            match_pulse <= tick & eq;
            wrap_pulse  <= tick & free_run & (cnt == '1);
            if (tick && eq && mode == MD_TIMER) begin
                toggle <= ~toggle;
            end
            if (clr) begin
                cnt <= '0;
            end else if (tick) begin
                cnt <= (eq && !free_run) ? '0 : cnt + 1'b1;
            end
        end
    end

endmodule

// File: rtl/mtimer8_regs.sv
module mtimer8_regs
    import mtimer8_pkg::*;
#(
    parameter logic [7:0] ADDR_CTRL = 8'h92,
    parameter logic [7:0] ADDR_CNT  = 8'h93,
    parameter logic [7:0] ADDR_DATA = 8'h94
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          wr,
    input  logic [7:0]    addr,
    input  logic [DW-1:0] wdata,
    input  logic [DW-1:0] cnt,
    input  logic          cap_edge,
    output ctrl_t         ctrl,
    output logic [DW-1:0] data,
    output logic          clr,
    output logic [DW-1:0] rdata
);
    logic [DW-1:0] cap_q;
    logic          wr_ctrl;
    logic          wr_data;

    assign wr_ctrl = wr && (addr == ADDR_CTRL);
    assign wr_data = wr && (addr == ADDR_DATA);
    assign clr     = wr_ctrl && wdata[0];

    always_ff @(posedge clk) begin
        if (rst) begin
            ctrl  <= '0;
            data  <= '1;
            cap_q <= '0;
        end else begin
            if (wr_ctrl) begin
                ctrl <= ctrl_t'(wdata[DW-1:1]);
            end
            if (wr_data) begin
                data <= wdata;
            end
            if (cap_edge && ctrl.en && is_capture(ctrl.mode)) begin
                cap_q <= cnt;
            end
        end
    end

    always_comb begin
        case (addr)
            ADDR_CTRL: rdata = {ctrl, 1'b0};
            ADDR_CNT:  rdata = cnt;
            ADDR_DATA: rdata = is_capture(ctrl.mode) ? cap_q : data;
            default:   rdata = '0;
        endcase
    end

endmodule

// File: rtl/mtimer8.sv
module mtimer8
    import mtimer8_pkg::*;
#(
    parameter logic [7:0] ADDR_CTRL   = 8'h92,
    parameter logic [7:0] ADDR_CNT    = 8'h93,
    parameter logic [7:0] ADDR_DATA   = 8'h94,
    parameter int         SYNC_STAGES = 2
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       bus_wr,
    input  logic [7:0] bus_addr,
    input  logic [7:0] bus_wdata,
    output logic [7:0] bus_rdata,
    input  logic       ext_count,
    input  logic       cap_event,
    input  logic       cap_falling,
    output logic       tmr_out,
    output logic       irq_match,
    output logic       irq_ovf
);
    ctrl_t         ctrl_q;
    logic [DW-1:0] data_q;
    logic [DW-1:0] cnt_q;
    logic          clr;
    logic          ext_rise;
    logic          cap_edge;
    logic          tick;
    logic          toggle;

    mtimer8_sync_edge #(.STAGES(SYNC_STAGES)) u_ext_sync (
        .clk(clk), .rst(rst), .din(ext_count), .sel_fall(1'b0), .edge_o(ext_rise)
    );

    mtimer8_sync_edge #(.STAGES(SYNC_STAGES)) u_cap_sync (
        .clk(clk), .rst(rst), .din(cap_event), .sel_fall(cap_falling), .edge_o(cap_edge)
    );

    mtimer8_tick_gen u_tick (
        .clk(clk), .rst(rst), .en(ctrl_q.en), .csel(ctrl_q.csel),
        .ext_rise(ext_rise), .tick(tick)
    );

    mtimer8_counter #(.W(DW)) u_cnt (
        .clk(clk), .rst(rst), .mode(ctrl_q.mode), .tick(tick), .clr(clr),
        .limit(data_q), .cnt(cnt_q), .match_pulse(irq_match),
        .wrap_pulse(irq_ovf), .toggle(toggle)
    );

    mtimer8_regs #(
        .ADDR_CTRL(ADDR_CTRL), .ADDR_CNT(ADDR_CNT), .ADDR_DATA(ADDR_DATA)
    ) u_regs (
        .clk(clk), .rst(rst), .wr(bus_wr), .addr(bus_addr), .wdata(bus_wdata),
        .cnt(cnt_q), .cap_edge(cap_edge), .ctrl(ctrl_q), .data(data_q),
        .clr(clr), .rdata(bus_rdata)
    );

    always_comb begin
        tmr_out = 1'b0;
        if (ctrl_q.en && ctrl_q.pe) begin
            case (ctrl_q.mode)
                MD_TIMER: tmr_out = toggle;
                MD_PWM:   tmr_out = (cnt_q < data_q);
                default:  tmr_out = 1'b0;
            endcase
        end
    end

endmodule

// File: rtl/mtimer8_checker.sv
module mtimer8_checker #(
    parameter logic [7:0] ADDR_CTRL = 8'h92
) (
    input logic       clk,
    input logic       rst,
    input logic       bus_wr,
    input logic [7:0] bus_addr,
    input logic       clr_bit,
    input logic       rd_bit0,
    input logic       tmr_out,
    input logic       irq_match,
    input logic       irq_ovf,
    input logic       en,
    input logic       pe,
    input logic [1:0] mode,
    input logic [7:0] cnt
);

    AST_CLR_READS_ZERO: assert property (@(posedge clk) disable iff (rst)
        (bus_addr == ADDR_CTRL) |-> !rd_bit0); // R3

    AST_DISABLED_HOLD: assert property (@(posedge clk) disable iff (rst)
        (!$past(en) && !($past(bus_wr) && $past(bus_addr) == ADDR_CTRL && $past(clr_bit)))
        |-> (cnt == $past(cnt))); // R6

    AST_MATCH_CLEARS: assert property (@(posedge clk) disable iff (rst)
        (irq_match && $past(mode) != 2'b01) |-> (cnt == 8'h00)); // R7

    AST_MATCH_SINGLE: assert property (@(posedge clk) disable iff (rst)
        irq_match |=> !irq_match); // R7

    AST_WRAP_AT_ZERO: assert property (@(posedge clk) disable iff (rst)
        irq_ovf |-> (cnt == 8'h00)); // R8

    AST_WRAP_PWM_ONLY: assert property (@(posedge clk) disable iff (rst)
        irq_ovf |-> ($past(mode) == 2'b01)); // R8

    AST_CAPTURE_QUIET: assert property (@(posedge clk) disable iff (rst)
        mode[1] |-> !tmr_out); // R10

    AST_PIN_GATED: assert property (@(posedge clk) disable iff (rst)
        (!pe || !en) |-> !tmr_out); // R12

endmodule

bind mtimer8 mtimer8_checker #(.ADDR_CTRL(ADDR_CTRL)) u_chk (
    .clk(clk), .rst(rst), .bus_wr(bus_wr), .bus_addr(bus_addr),
    .clr_bit(bus_wdata[0]), .rd_bit0(bus_rdata[0]), .tmr_out(tmr_out),
    .irq_match(irq_match), .irq_ovf(irq_ovf), .en(ctrl_q.en), .pe(ctrl_q.pe),
    .mode(ctrl_q.mode), .cnt(cnt_q)
);

// File: tb/mtimer8_test.sv
module mtimer8_test;
    localparam int CLK_PERIOD = 10;
    localparam int WATCHDOG   = 150000;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       bus_wr = 1'b0;
    logic [7:0] bus_addr = 8'h93;
    logic [7:0] bus_wdata = 8'h00;
    logic       ext_count = 1'b0;
    logic       cap_event = 1'b0;
    logic       cap_falling = 1'b0;
    logic [7:0] bus_rdata;
    logic       tmr_out, irq_match, irq_ovf;

    int checks = 0;
    int fails = 0;
    int cycles = 0;
    bit cmp_on = 1'b0;
    bit done = 1'b0;
    string cur_req = "R1";

    // reference model state
    int m_ctrl, m_cnt, m_dr, m_cdr, m_pre;
    bit m_tog, m_irqm, m_irqo;
    bit e1, e2, e3, c1, c2, c3;

    mtimer8 uut (
        .clk(clk), .rst(rst), .bus_wr(bus_wr), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .ext_count(ext_count),
        .cap_event(cap_event), .cap_falling(cap_falling), .tmr_out(tmr_out),
        .irq_match(irq_match), .irq_ovf(irq_ovf)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    task automatic chk(string req, int act, int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s at cycle %0d: actual %02h expected %02h", req, cycles, act, exp);
        end
    endtask

    // behavioural model, advanced once per rising edge
    always @(posedge clk) begin
        cycles++;
        if (rst) begin
            m_ctrl = 0; m_cnt = 0; m_dr = 255; m_cdr = 0; m_pre = 0;
            m_tog = 0; m_irqm = 0; m_irqo = 0;
            e1 = 0; e2 = 0; e3 = 0; c1 = 0; c2 = 0; c3 = 0;
        end else begin
            bit en, tick, cedge, im, io, nt;
            int mode, cks, div, nc;
            en = m_ctrl[7];
            mode = (m_ctrl >> 4) & 3;
            cks = (m_ctrl >> 1) & 7;
            case (cks)
                0: div = 2;    1: div = 4;    2: div = 8;    3: div = 32;
                4: div = 128;  5: div = 512;  6: div = 2048; default: div = 1;
            endcase
            tick = en && ((cks == 7) ? (e2 && !e3) : ((m_pre % div) == div - 1));
            cedge = cap_falling ? (c3 && !c2) : (c2 && !c3);
            nc = m_cnt; nt = m_tog; im = 0; io = 0;
            if (tick) begin
                if (mode == 1) begin
                    if (m_cnt == m_dr) im = 1;
                    if (m_cnt == 255) io = 1;
                    nc = (m_cnt + 1) % 256;
                end else if (m_cnt == m_dr) begin
                    nc = 0; im = 1;
                    if (mode == 0) nt = !m_tog;
                end else begin
                    nc = m_cnt + 1;
                end
            end
            if (bus_wr && bus_addr == 8'h92 && bus_wdata[0]) nc = 0;
            if (en && mode >= 2 && cedge) m_cdr = m_cnt;
            if (bus_wr && bus_addr == 8'h92) m_ctrl = bus_wdata & 8'hFE;
            if (bus_wr && bus_addr == 8'h94) m_dr = bus_wdata;
            m_pre = en ? (m_pre + 1) % 2048 : 0;
            e3 = e2; e2 = e1; e1 = ext_count;
            c3 = c2; c2 = c1; c1 = cap_event;
            m_cnt = nc; m_tog = nt; m_irqm = im; m_irqo = io;
        end
    end

    function automatic int exp_rdata(logic [7:0] a);
        case (a)
            8'h92: return m_ctrl;
            8'h93: return m_cnt;
            8'h94: return m_ctrl[5] ? m_cdr : m_dr;
            default: return 0;
        endcase
    endfunction

    function automatic int exp_out();
        int mode = (m_ctrl >> 4) & 3;
        if (!(m_ctrl[7] && m_ctrl[6])) return 0;
        if (mode == 0) return int'(m_tog);
        if (mode == 1) return (m_cnt < m_dr) ? 1 : 0;
        return 0;
    endfunction

    always @(negedge clk) begin
        if (cmp_on && !done) begin
            chk({cur_req, " rdata"}, int'(bus_rdata), exp_rdata(bus_addr));
            chk({cur_req, " tmr_out"}, int'(tmr_out), exp_out());
            chk({cur_req, " irq_match"}, int'(irq_match), int'(m_irqm));
            chk({cur_req, " irq_ovf"}, int'(irq_ovf), int'(m_irqo));
        end
    end

    always @(posedge clk) begin
        if (cycles >= WATCHDOG && !done) begin
            done = 1'b1;
            fails++;
            $display("FAIL watchdog: actual %0d cycles expected under %0d", cycles, WATCHDOG);
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

    task automatic step(int n);
        repeat (n) begin
            @(posedge clk);
            #1;
        end
    endtask

    task automatic wr(logic [7:0] a, logic [7:0] d);
        @(posedge clk); #1;
        bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        @(posedge clk); #1;
        bus_wr = 1'b0; bus_addr = 8'h93;
    endtask

    task automatic rd_check(string req, logic [7:0] a, int exp);
        @(posedge clk); #1;
        bus_addr = a;
        @(negedge clk);
        chk(req, int'(bus_rdata), exp);
    endtask

    task automatic ext_pulses(int n, int gap);
        repeat (n) begin
            ext_count = 1'b1; step(gap);
            ext_count = 1'b0; step(gap);
        end
    endtask

    initial begin
        // R1: reset values
        step(3);
        rd_check("R1 ctrl", 8'h92, 8'h00);
        rd_check("R1 counter", 8'h93, 8'h00);
        rd_check("R1 data", 8'h94, 8'hFF);
        chk("R1 tmr_out", int'(tmr_out), 0);
        chk("R1 irq", int'(irq_match | irq_ovf), 0);
        @(posedge clk); #1;
        rst = 1'b0; bus_addr = 8'h93;
        cmp_on = 1'b1;

        // R7 / R4: compare mode, divide by 2, limit 5
        cur_req = "R7";
        wr(8'h94, 8'h05);
        wr(8'h92, 8'hC0);
        step(60);
        cur_req = "R4";
        wr(8'h92, 8'hC4);  // divide by 8
        step(120);
        wr(8'h92, 8'hC6);  // divide by 32
        step(300);

        // R3: clear strobe
        cur_req = "R3";
        wr(8'h92, 8'hC7);
        @(negedge clk);
        chk("R3 counter cleared", int'(bus_rdata), 0);
        rd_check("R3 strobe reads 0", 8'h92, 8'hC6);
        step(40);
        wr(8'h92, 8'hC6);  // clear bit 0: no effect
        step(40);

        // R4: divide by 128 and by 512, limit 1
        cur_req = "R4";
        wr(8'h94, 8'h01);
        wr(8'h92, 8'hC8);
        step(600);
        wr(8'h92, 8'hCA);
        step(1200);

        // R8 / R9: PWM at three duty settings
        cur_req = "R8";
        wr(8'h92, 8'h11);  // disabled, clear
        wr(8'h94, 8'h40);
        wr(8'h92, 8'hD0);
        step(540);
        cur_req = "R9";
        wr(8'h94, 8'h00);
        step(530);
        wr(8'h94, 8'hFF);
        step(530);

        // R12: pin enable off in PWM
        cur_req = "R12";
        wr(8'h94, 8'h80);
        wr(8'h92, 8'h90);
        step(100);
        chk("R12 pin low", int'(tmr_out), 0);

        // R6: disabled
        cur_req = "R6";
        wr(8'h92, 8'h50);
        rd_check("R6 hold", 8'h93, m_cnt);
        step(60);
        rd_check("R6 still held", 8'h93, m_cnt);
        chk("R6 pin low", int'(tmr_out), 0);

        // R5: external count, limit 3
        cur_req = "R5";
        wr(8'h92, 8'h41);
        wr(8'h94, 8'h03);
        wr(8'h92, 8'hCE);
        ext_pulses(12, 3);
        ext_pulses(6, 1);
        rd_check("R5 count after 18 edges", 8'h93, 18 % 4);

        // R10 / R11: capture mode
        cur_req = "R10";
        wr(8'h92, 8'h01);
        wr(8'h94, 8'h30);
        wr(8'h92, 8'hE0);
        bus_addr = 8'h94;
        step(20);
        cap_event = 1'b1; step(7);
        cap_event = 1'b0; step(30);
        cap_falling = 1'b1;
        step(10);
        cap_event = 1'b1; step(9);
        cap_event = 1'b0; step(20);
        wr(8'h92, 8'hF2);  // mode 11, divide by 4
        bus_addr = 8'h94;
        cap_falling = 1'b0;
        step(25);
        cap_event = 1'b1; step(15);
        cap_event = 1'b0; step(15);
        rd_check("R10 capture value", 8'h94, m_cdr);
        cur_req = "R11";
        wr(8'h94, 8'h20);
        rd_check("R11 capture shown", 8'h94, m_cdr);
        wr(8'h92, 8'h80);
        rd_check("R11 data shown", 8'h94, 8'h20);
        rd_check("R11 unused addr", 8'h95, 8'h00);

        // R2: control layout
        cur_req = "R2";
        wr(8'h92, 8'hFF);
        rd_check("R2 readback", 8'h92, 8'hFE);
        step(20);

        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

endmodule